// File: doc/BRIEF.md
# I2C Slave Bus Front End

This block is the bit-level front end of an I2C slave that serves a serial memory. It takes the raw clock and data lines from the pads, passes each through a two-flop synchronizer and a persistence filter that throws away short spikes, and finds bus conditions on the cleaned lines. A falling data edge while the clock is high is a Start. A rising data edge while the clock is high is a Stop. Between those conditions it shifts received bytes in, most significant bit first, sampling on clock rising edges. It shifts read bytes out on the same line through an active-low pull-down enable.

A command sequencer sits above the block. It sees single-cycle events for Start, Stop, a received byte, the beginning of each acknowledge slot and the master's acknowledge during reads. It controls two things through level inputs: whether the block pulls the line low in the acknowledge slot of a received byte, and whether the next byte is transmitted. Each Stop event carries a flag that tells the sequencer whether the Stop fell in the slot right after an acknowledge. A write cycle may only be triggered by a Stop in that position. After a master NoAck on read data, the block goes to standby and ignores clocks until the next Start.

Top module: `i2c_slave_front`

## Requirements
- R1: A falling data edge while the filtered clock is high raises `ev_start` for one cycle, releases `sda_pull` and restarts the bit count at zero. This also happens in the middle of a byte, without any `ev_stop` before it.
- R2: A rising data edge while the filtered clock is high raises `ev_stop` for one cycle and releases `sda_pull`. The block then ignores clock edges until the next Start.
- R3: Data is sampled on clock rising edges and is taken most significant bit first. After the eighth rising edge of a received byte, `ev_byte` pulses and `rx_byte` holds the byte.
- R4: On the clock falling edge that follows the eighth bit of a received byte, `sda_pull` takes the value of `ack_en`. It holds that value through the ninth clock and is released on the next falling edge.
- R5: If `rd_mode` is 1 on the falling edge that ends an acknowledge slot, the next byte is `tx_data`, sent most significant bit first. `sda_pull` = 1 drives a 0 bit, and `sda_pull` is released for that byte's acknowledge slot.
- R6: On the ninth rising edge of a transmitted byte, `ev_mack` pulses. `mack_ok` is 1 if the data line is low (Ack) and 0 if it is high (NoAck). A NoAck puts the block in standby: no further `ev_byte` and no pull-down until a Start.
- R7: `sda_pull` never changes while the clock line stays high.
- R8: A pulse on either line that lasts fewer than `FILT_CYCLES` system clocks has no effect: no clock edge, no Start and no Stop.
- R9: `stop_after_ack` is 1 together with `ev_stop` only when the transfer is active, an acknowledge slot has completed, and the Stop's own clock is the only rising edge since that slot. In every other case it is 0.
- R10: After reset, every output is 0.
- R11: `ev_ack_slot` pulses once at the start of every acknowledge slot, for received and transmitted bytes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| ack_en | input | 1 | Acknowledge the current received byte |
| rd_mode | input | 1 | Transmit the next byte |
| tx_data | input | BYTE_W | Byte to transmit next |
| sda_pull | output | 1 | Pull-down enable for the data line (1 drives low) |
| ev_start | output | 1 | Start or repeated Start seen |
| ev_stop | output | 1 | Stop seen |
| stop_after_ack | output | 1 | Stop fell in the slot right after an acknowledge |
| ev_byte | output | 1 | Received byte complete |
| rx_byte | output | BYTE_W | Last received byte |
| ev_ack_slot | output | 1 | Acknowledge slot begins |
| ev_mack | output | 1 | Master acknowledge sampled during a read |
| mack_ok | output | 1 | Last master acknowledge was Ack |

## Verification
The hardest case to reach from the ports is a spike on the data line during a clock-high phase. Such a spike looks exactly like a false Start or Stop, and only the filter stands between it and a wrecked transfer. The bench builds a wired-AND bus from its own drive and the block's pull-down. In the middle of a high phase it inverts the data line for fewer clocks than the filter threshold, once on a 0 bit and once on a 1 bit. It also sends a short clock spike during a low phase. The bench then requires that no extra Start or Stop event appears and that the byte arrives intact.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // Bus-condition events produced by the condition detector
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/sfe_line_filter.sv
module sfe_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{1'b1}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign raw = sync_q[SYNC_STAGES-1];

  // A new level is accepted only after it has persisted FILT_CYCLES clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b1;
      cnt     <= '0;
    end else if (raw == level_o) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_CYCLES - 1)) begin
      level_o <= raw;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfe_cond_detect.sv
module sfe_cond_detect
  import sfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl,
  input  logic    sda,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ev    <= '0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      ev.start <= scl & scl_q & sda_q & ~sda;
      ev.stop  <= scl & scl_q & ~sda_q & sda;
      ev.rise  <= scl & ~scl_q;
      ev.fall  <= ~scl & scl_q;
      ev.sda   <= sda;
    end
  end
endmodule

// File: rtl/sfe_bit_engine.sv
module sfe_bit_engine
  import sfe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_ev_t           ev,
  input  logic              ack_en,
  input  logic              rd_mode,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_pull,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              stop_after_ack,
  output logic              ev_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_ack_slot,
  output logic              ev_mack,
  output logic              mack_ok
);
  localparam int SW = $clog2(BYTE_W + 2);
  localparam logic [SW-1:0] LAST_BIT = SW'(BYTE_W - 1);
  localparam logic [SW-1:0] ACK_POS  = SW'(BYTE_W);
  localparam logic [SW-1:0] ACK_HIGH = SW'(BYTE_W + 1);

  logic              active, tx_active, seen_ack;
  logic [SW-1:0]     slot;          // clock rising edges seen in this byte
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active         <= 1'b0;
      tx_active      <= 1'b0;
      seen_ack       <= 1'b0;
      slot           <= '0;
      rx_sh          <= '0;
      tx_sh          <= '0;
      sda_pull       <= 1'b0;
      ev_start       <= 1'b0;
      ev_stop        <= 1'b0;
      stop_after_ack <= 1'b0;
      ev_byte        <= 1'b0;
      rx_byte        <= '0;
      ev_ack_slot    <= 1'b0;
      ev_mack        <= 1'b0;
      mack_ok        <= 1'b0;
    end else begin
      ev_start       <= 1'b0;
      ev_stop        <= 1'b0;
      stop_after_ack <= 1'b0;
      ev_byte        <= 1'b0;
      ev_ack_slot    <= 1'b0;
      ev_mack        <= 1'b0;
      if (ev.start) begin
        ev_start  <= 1'b1;
        active    <= 1'b1;
        tx_active <= 1'b0;
        seen_ack  <= 1'b0;
        slot      <= '0;
        sda_pull  <= 1'b0;
      end else if (ev.stop) begin
        ev_stop        <= 1'b1;
        stop_after_ack <= active & seen_ack & (slot == SW'(1));
        active         <= 1'b0;
        tx_active      <= 1'b0;
        seen_ack       <= 1'b0;
        slot           <= '0;
        sda_pull       <= 1'b0;
      end else if (active && ev.rise) begin
        if (slot < ACK_POS) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], ev.sda};
          slot  <= slot + 1'b1;
          if (slot == LAST_BIT && !tx_active) begin
            ev_byte <= 1'b1;
            rx_byte <= {rx_sh[BYTE_W-2:0], ev.sda};
          end
        end else if (slot == ACK_POS) begin
          slot <= ACK_HIGH;
          if (tx_active) begin
            ev_mack <= 1'b1;
            mack_ok <= ~ev.sda;
            if (ev.sda) begin
              active    <= 1'b0;
              tx_active <= 1'b0;
              seen_ack  <= 1'b0;
              slot      <= '0;
              sda_pull  <= 1'b0;
            end
          end
        end
      end else if (active && ev.fall) begin
        if (slot == ACK_POS) begin
          ev_ack_slot <= 1'b1;
          sda_pull    <= tx_active ? 1'b0 : ack_en;
        end else if (slot == ACK_HIGH) begin
          slot      <= '0;
          seen_ack  <= 1'b1;
          tx_active <= rd_mode;
          if (rd_mode) begin
            sda_pull <= ~tx_data[BYTE_W-1];
            tx_sh    <= {tx_data[BYTE_W-2:0], 1'b0};
          end else begin
            sda_pull <= 1'b0;
          end
        end else if (tx_active && slot != '0) begin
          sda_pull <= ~tx_sh[BYTE_W-1];
          tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_front.sv
module i2c_slave_front
  import sfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 5,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ack_en,
  input  logic              rd_mode,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_pull,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              stop_after_ack,
  output logic              ev_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_ack_slot,
  output logic              ev_mack,
  output logic              mack_ok
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] flt_lvl;
  logic              scl_flt, sda_flt;
  bus_ev_t           bus_ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    sfe_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_flt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .level_o(flt_lvl[g])
    );
  end

  assign scl_flt = flt_lvl[0];
  assign sda_flt = flt_lvl[1];

  sfe_cond_detect u_det (
    .clk(clk),
    .rst(rst),
    .scl(scl_flt),
    .sda(sda_flt),
    .ev (bus_ev)
  );

  sfe_bit_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .ev            (bus_ev),
    .ack_en        (ack_en),
    .rd_mode       (rd_mode),
    .tx_data       (tx_data),
    .sda_pull      (sda_pull),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .stop_after_ack(stop_after_ack),
    .ev_byte       (ev_byte),
    .rx_byte       (rx_byte),
    .ev_ack_slot   (ev_ack_slot),
    .ev_mack       (ev_mack),
    .mack_ok       (mack_ok)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rst,
  input logic scl_flt,
  input logic sda_pull,
  input logic ev_start,
  input logic ev_stop,
  input logic stop_after_ack,
  input logic ev_byte,
  input logic ev_ack_slot,
  input logic ev_mack,
  input logic mack_ok
);
  // R7: pull-down only moves while the filtered clock is low
  a_r7_pull_only_scl_low: assert property (@(posedge clk) disable iff (rst)
    (scl_flt && $past(scl_flt) && $past(scl_flt, 2)) |-> $stable(sda_pull));

  // R1: a Start leaves the line released
  a_r1_start_releases: assert property (@(posedge clk) disable iff (rst)
    ev_start |-> !sda_pull);

  // R2: a Stop leaves the line released
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
    ev_stop |-> !sda_pull);

  // R9: the flag only accompanies a Stop event
  a_r9_flag_with_stop: assert property (@(posedge clk) disable iff (rst)
    stop_after_ack |-> ev_stop);

  // R3: byte-level events never coincide
  a_r3_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_start, ev_stop, ev_byte, ev_ack_slot, ev_mack}));

  // R6: after a NoAck the line stays released
  a_r6_nack_releases: assert property (@(posedge clk) disable iff (rst)
    (ev_mack && !mack_ok) |=> !sda_pull);
endmodule

bind i2c_slave_front sfe_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_flt       (scl_flt),
  .sda_pull      (sda_pull),
  .ev_start      (ev_start),
  .ev_stop       (ev_stop),
  .stop_after_ack(stop_after_ack),
  .ev_byte       (ev_byte),
  .ev_ack_slot   (ev_ack_slot),
  .ev_mack       (ev_mack),
  .mack_ok       (mack_ok)
);

// File: tb/test_i2c_slave_front.sv
`timescale 1ns/1ps
module test_i2c_slave_front;
  localparam int H = 40;   // half bus-clock period in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic ack_en = 1'b0, rd_mode = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_i, sda_i;
  logic sda_pull, ev_start, ev_stop, stop_after_ack, ev_byte, ev_ack_slot, ev_mack, mack_ok;
  logic [7:0] rx_byte;

  always #10 clk = ~clk;

  // Wired-AND bus: master drive, block pull-down, plus injected spikes
  assign scl_i = m_scl ^ g_scl;
  assign sda_i = (m_sda & ~sda_pull) ^ g_sda;

  i2c_slave_front i_i2c_slave_front (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .ack_en(ack_en), .rd_mode(rd_mode), .tx_data(tx_data),
    .sda_pull(sda_pull), .ev_start(ev_start), .ev_stop(ev_stop),
    .stop_after_ack(stop_after_ack), .ev_byte(ev_byte), .rx_byte(rx_byte),
    .ev_ack_slot(ev_ack_slot), .ev_mack(ev_mack), .mack_ok(mack_ok)
  );

  int n_chk = 0, n_err = 0;
  int cnt_start = 0, cnt_stop = 0, cnt_slot = 0, r7_viol = 0;
  int q_byte[$], q_flag[$], q_mack[$];
  logic [7:0] glitch_mask = 8'h00;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk_q(input string what, input int q[$], input int exp[$]);
    chk({what, " count"}, q.size(), exp.size());
    if (q.size() == exp.size())
      foreach (exp[k]) chk(what, q[k], exp[k]);
  endtask

  task automatic clr();
    cnt_start = 0; cnt_stop = 0; cnt_slot = 0;
    q_byte.delete(); q_flag.delete(); q_mack.delete();
  endtask

  // Per-clock monitor, sampled away from both clock edges
  logic scl_p1 = 1'b1, scl_p2 = 1'b1, pull_p = 1'b0;
  always begin
    @(posedge clk); #5;
    if (!rst) begin
      if (ev_start) cnt_start++;
      if (ev_stop) begin cnt_stop++; q_flag.push_back(int'(stop_after_ack)); end
      if (ev_ack_slot) cnt_slot++;
      if (ev_byte) q_byte.push_back(int'(rx_byte));
      if (ev_mack) q_mack.push_back(int'(mack_ok));
      if (m_scl && scl_p1 && scl_p2 && sda_pull != pull_p) r7_viol++;
    end
    scl_p2 = scl_p1; scl_p1 = m_scl; pull_p = sda_pull;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(H);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; w(H); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    m_sda = b; w(H/2);
    if (glitch) begin g_scl = 1'b1; w(3); g_scl = 1'b0; w(H/2 - 3); end
    else w(H/2);
    m_scl = 1'b1; w(H/4);
    if (glitch) begin g_sda = 1'b1; w(3); g_sda = 1'b0; w(H/4 - 3); end
    else w(H/4);
    w(H/2); m_scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch_mask[i]);
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H/2);
    chk({req, " ack pull"}, int'(sda_pull), int'(exp_ack));
    w(H/2); m_scl = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic mack, input logic [7:0] nxt);
    logic [7:0] got;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); m_scl = 1'b1; w(H/2); got[i] = sda_i; w(H/2); m_scl = 1'b0;
    end
    tx_data = nxt;
    m_sda = ~mack; w(H); m_scl = 1'b1; w(H/2);
    chk("R5 released in master ack slot", int'(sda_pull), 0);
    w(H/2); m_scl = 1'b0;
    chk("R5 transmitted byte", int'(got), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    w(5); rst = 1'b0; w(2);
    // R10: reset state
    chk("R10 sda_pull", int'(sda_pull), 0);
    chk("R10 events", int'({ev_start, ev_stop, ev_byte, ev_ack_slot, ev_mack}), 0);
    chk("R10 rx_byte", int'(rx_byte), 0);
    chk("R10 flags", int'({stop_after_ack, mack_ok}), 0);
    w(H);

    // Two-byte write, acknowledged, Stop in the slot after the ack
    clr(); ack_en = 1'b1;
    start_c(); write_byte(8'hA0, 1'b1, "R4"); write_byte(8'h5C, 1'b1, "R4"); stop_c(); w(H);
    chk("R1 start count", cnt_start, 1);
    chk("R2 stop count", cnt_stop, 1);
    chk_q("R3 received bytes", q_byte, '{8'hA0, 8'h5C});
    chk_q("R9 flag after ack", q_flag, '{1});
    chk("R11 ack slot count", cnt_slot, 2);

    // Byte not acknowledged when ack_en is low; Stop still after ack slot
    clr(); ack_en = 1'b0;
    start_c(); write_byte(8'h3F, 1'b0, "R4 no-ack"); stop_c(); w(H);
    chk_q("R9 flag after unacked slot", q_flag, '{1});
    ack_en = 1'b1;

    // Stop in the middle of a byte, and Stop right after Start
    clr();
    start_c(); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); stop_c(); w(H);
    start_c(); stop_c(); w(H);
    chk_q("R9 flag mid-byte and empty", q_flag, '{0, 0});
    chk("R3 no byte on partial", q_byte.size(), 0);

    // Repeated Start in the middle of a byte
    clr();
    start_c(); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    start_c(); write_byte(8'h96, 1'b1, "R1"); stop_c(); w(H);
    chk("R1 repeated start count", cnt_start, 2);
    chk("R1 no stop between", cnt_stop, 1);
    chk_q("R1 byte after restart", q_byte, '{8'h96});

    // Read: address byte, Ack on first data byte, NoAck on second, then ignored clocks
    clr(); rd_mode = 1'b1; tx_data = 8'hC3;
    start_c(); write_byte(8'hA1, 1'b1, "R4 address");
    read_byte(8'hC3, 1'b1, 8'h5A);
    read_byte(8'h5A, 1'b0, 8'hFF);
    rd_mode = 1'b0;
    write_byte(8'h00, 1'b0, "R6 standby");
    stop_c(); w(H);
    chk_q("R6 master ack values", q_mack, '{1, 0});
    chk_q("R6 no byte in standby", q_byte, '{8'hA1});
    chk_q("R9 flag after standby", q_flag, '{0});
    chk("R11 ack slots in read", cnt_slot, 3);

    // Spikes shorter than the filter threshold on both lines
    clr(); glitch_mask = 8'b0001_1000;
    start_c(); write_byte(8'h6B, 1'b1, "R8"); glitch_mask = 8'h00; stop_c(); w(H);
    chk("R8 no false start", cnt_start, 1);
    chk("R8 no false stop", cnt_stop, 1);
    chk_q("R8 byte intact", q_byte, '{8'h6B});

    chk("R7 pull changes while clock high", r7_viol, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule